// File: doc/BRIEF.md
# Flash Status Byte Generator

This block forms the byte a flash memory returns on a bus read while its internal program/erase engine is working, is held in erase suspend, or has stopped on a failure. It watches the engine state, the kind of operation, the data being programmed, where the read lands (inside or outside a block marked for erase, and which block), whether the block-erase collection window has closed, and a per-block failure map. From these it builds five status flags. When no status is due, it passes the array byte through.

The two toggle flags are flip-flops that advance on read strobes, not on the clock. Host software can therefore tell "still working" from "finished" by comparing two successive reads. The second toggle flag follows the read address, so a host can also find which blocks are being erased or failed to erase. A short status window is produced for an operation aimed at protected storage, which finishes without changing anything: about 1 µs for a program and about 100 µs for an erase, counted in clock cycles.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle flip-flops are 0, the error flag is 0 and no protection window is open. With the engine idle, `stat_sel` is 0 and `rd_byte` equals `array_byte`.
- R2: The polling flag is bit 7. During a program (`op_kind`=00), or a program error, it is the inverse of bit 7 of the data latched at `prog_start`/`prot_abort`. During an erase (`op_kind`=01 chip, 10 block) it is 0. On a suspend read inside an erasing block it is 1.
- R3: The toggle flag is bit 6. It inverts after every read strobe while the engine is busy, in a protection window, or in error, at any address. In suspend it holds its value.
- R4: The error flag is bit 5. It is set one cycle after `fail_evt`, or after a `prog_start` whose `prog_wdata` has a 1 where `prog_cur` has a 0. It holds until `clr_cmd`. A set and a clear in the same cycle leave it set.
- R5: The erase-timer flag is bit 3. It is 1 during a chip erase, equals `erase_started` during a block erase, and is 0 for programs and in suspend.
- R6: The alternate toggle flag is bit 2. During an erase it inverts after a read strobe only when `in_erase_blk` is 1; on other reads it holds. For programs it reads 0.
- R7: After an erase error, bit 2 inverts only on reads whose `rd_blk` indexes a set bit of `blk_fail`, while bit 6 inverts on every read.
- R8: In suspend, a read with `in_erase_blk`=0 returns `array_byte` with `stat_sel`=0. A read with `in_erase_blk`=1 returns status with bit 7 = 1, bit 6 steady and bit 2 toggling.
- R9: A `prot_abort` pulse opens a window of PROT_PROG_CYC cycles (program) or PROT_ERASE_CYC cycles (erase, `prot_is_erase`=1). During the window status is shown with bit 6 toggling, bit 5 = 0, bit 3 = `prot_is_erase`, and bit 2 held (0 for program). Afterwards the array byte returns.
- R10: Bits 4, 1 and 0 are 0 whenever `stat_sel` is 1.
- R11: Mode priority is error, then protection window, then busy, then suspend. A set error flag overrides `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| eng_busy | input | 1 | Engine is executing a program or erase |
| eng_susp | input | 1 | Erase is suspended |
| op_kind | input | 2 | 00 program, 01 chip erase, 10 block erase |
| erase_started | input | 1 | Block-erase collection window has closed |
| in_erase_blk | input | 1 | Read address lies in a block selected for erase |
| rd_blk | input | BLK_W | Block index of the read address |
| blk_fail | input | NUM_BLK | Per-block erase failure flags |
| rd_stb | input | 1 | One-cycle bus read strobe |
| prog_start | input | 1 | Program accepted; latches data and checks 0-to-1 |
| prog_cur | input | 8 | Current cell contents at the program address |
| prog_wdata | input | 8 | Data being programmed |
| prot_abort | input | 1 | Operation hit protected storage; opens window |
| prot_is_erase | input | 1 | Aborted operation was an erase |
| fail_evt | input | 1 | Engine reports a failed operation |
| clr_cmd | input | 1 | Read/Reset command clears the error flag |
| array_byte | input | 8 | Array data for the read address |
| rd_byte | output | 8 | Byte returned to the bus |
| stat_sel | output | 1 | 1 when rd_byte carries status |

## Verification
The bench tracks both toggle values itself and checks whether each read flips them. A design that advanced on clocks instead of reads would drift between strobes. One that toggled bit 6 in suspend, or bit 2 outside erasing or failed blocks, would give the wrong bit on the next read. Edge cases driven are:
- a 0-to-1 program attempt;
- a clear and a failure in the same cycle, where a clear-wins design would drop the flag;
- an error raised while `eng_busy` is still high, where a wrong priority would show busy status;
- suspend reads on both sides of the erasing block;
- both protection windows, where a design with a swapped or missing length would return array data early or keep status late.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_CHIP  = 2'b01,
    OP_BLOCK = 2'b10
  } fsg_op_e;

  typedef enum logic [2:0] {
    MD_IDLE = 3'd0,
    MD_BUSY = 3'd1,
    MD_SUSP = 3'd2,
    MD_PROT = 3'd3,
    MD_ERR  = 3'd4
  } fsg_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SB_POLL = 7;
  localparam int unsigned SB_TOG  = 6;
  localparam int unsigned SB_ERR  = 5;
  localparam int unsigned SB_TMR  = 3;
  localparam int unsigned SB_ALT  = 2;
endpackage

// File: rtl/fsg_op_latch.sv
module fsg_op_latch
  import fsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prot_abort,
  input  logic              prot_is_erase,
  input  logic [BYTE_W-1:0] prog_cur,
  input  logic [BYTE_W-1:0] prog_wdata,
  input  logic              fail_evt,
  input  logic              clr_cmd,
  output logic              err_q,
  output logic              pbit_q
);
  logic bad_bits;
  logic err_d;
  logic pbit_d;
  logic pbit_en;

  assign bad_bits = |(prog_wdata & ~prog_cur);
  assign pbit_en  = prog_start | (prot_abort & ~prot_is_erase);

  always_comb begin
    err_d = err_q;
    if (clr_cmd) err_d = 1'b0;
    if (fail_evt | (prog_start & bad_bits)) err_d = 1'b1;
  end

  always_comb begin
    pbit_d = pbit_q;
    if (pbit_en) pbit_d = prog_wdata[SB_POLL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pbit_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      pbit_q <= pbit_d;
    end
  end
endmodule

// File: rtl/fsg_prot_window.sv
module fsg_prot_window #(
  parameter int unsigned PROG_CYC  = 250,
  parameter int unsigned ERASE_CYC = 25000,
  localparam int unsigned MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_abort,
  input  logic prot_is_erase,
  output logic active,
  output logic is_erase_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ers_d;

  always_comb begin
    cnt_d = cnt_q;
    ers_d = is_erase_q;
    if (prot_abort) begin
      cnt_d = prot_is_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      ers_d = prot_is_erase;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      is_erase_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      is_erase_q <= ers_d;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);
  logic d;

  always_comb begin
    d = q;
    if (adv) d = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/fsg_mode_dec.sv
module fsg_mode_dec
  import fsg_pkg::*;
#(
  parameter int unsigned NUM_BLK = 19,
  localparam int unsigned BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               err_q,
  input  logic               prot_act,
  input  logic               eng_busy,
  input  logic               eng_susp,
  input  logic [1:0]         op_kind,
  input  logic               in_erase_blk,
  input  logic [BLK_W-1:0]   rd_blk,
  input  logic [NUM_BLK-1:0] blk_fail,
  input  logic               rd_stb,
  output fsg_mode_e          mode,
  output logic               adv6,
  output logic               adv2,
  output logic               stat_sel
);
  logic blk_hit;
  logic op_erase;

  assign op_erase = (op_kind != OP_PROG);

  always_comb begin
    blk_hit = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (rd_blk == BLK_W'(i)) blk_hit = blk_fail[i];
    end
  end

  always_comb begin
    if (err_q)                      mode = MD_ERR;
    else if (prot_act)              mode = MD_PROT;
    else if (eng_busy && !eng_susp) mode = MD_BUSY;
    else if (eng_susp)              mode = MD_SUSP;
    else                            mode = MD_IDLE;
  end

  always_comb begin
    adv6     = 1'b0;
    adv2     = 1'b0;
    stat_sel = 1'b0;
    unique case (mode)
      MD_BUSY: begin
        stat_sel = 1'b1;
        adv6     = rd_stb;
        adv2     = rd_stb & op_erase & in_erase_blk;
      end
      MD_PROT: begin
        stat_sel = 1'b1;
        adv6     = rd_stb;
      end
      MD_ERR: begin
        stat_sel = 1'b1;
        adv6     = rd_stb;
        adv2     = rd_stb & op_erase & blk_hit;
      end
      MD_SUSP: begin
        stat_sel = in_erase_blk;
        adv2     = rd_stb & in_erase_blk;
      end
      default: begin
        stat_sel = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int unsigned NUM_BLK        = 19,
  parameter int unsigned PROT_PROG_CYC  = 250,
  parameter int unsigned PROT_ERASE_CYC = 25000,
  localparam int unsigned BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_busy,
  input  logic               eng_susp,
  input  logic [1:0]         op_kind,
  input  logic               erase_started,
  input  logic               in_erase_blk,
  input  logic [BLK_W-1:0]   rd_blk,
  input  logic [NUM_BLK-1:0] blk_fail,
  input  logic               rd_stb,
  input  logic               prog_start,
  input  logic [7:0]         prog_cur,
  input  logic [7:0]         prog_wdata,
  input  logic               prot_abort,
  input  logic               prot_is_erase,
  input  logic               fail_evt,
  input  logic               clr_cmd,
  input  logic [7:0]         array_byte,
  output logic [7:0]         rd_byte,
  output logic               stat_sel
);
  localparam int unsigned N_TOG = 2;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic       err_q;
  logic       pbit_q;
  logic       prot_act;
  logic       prot_ers;
  fsg_mode_e  mode;
  logic       adv6, adv2;
  logic       tog6, tog2;
  logic [N_TOG-1:0] tog_adv, tog_q;
  logic       op_erase;
  logic [7:0] stat_byte;

  fsg_op_latch u_op (
    .clk(clk), .rst_n(rst_sync_n),
    .prog_start(prog_start), .prot_abort(prot_abort),
    .prot_is_erase(prot_is_erase),
    .prog_cur(prog_cur), .prog_wdata(prog_wdata),
    .fail_evt(fail_evt), .clr_cmd(clr_cmd),
    .err_q(err_q), .pbit_q(pbit_q)
  );

  fsg_prot_window #(.PROG_CYC(PROT_PROG_CYC), .ERASE_CYC(PROT_ERASE_CYC)) u_prot (
    .clk(clk), .rst_n(rst_sync_n),
    .prot_abort(prot_abort), .prot_is_erase(prot_is_erase),
    .active(prot_act), .is_erase_q(prot_ers)
  );

  fsg_mode_dec #(.NUM_BLK(NUM_BLK)) u_mode (
    .err_q(err_q), .prot_act(prot_act),
    .eng_busy(eng_busy), .eng_susp(eng_susp), .op_kind(op_kind),
    .in_erase_blk(in_erase_blk), .rd_blk(rd_blk), .blk_fail(blk_fail),
    .rd_stb(rd_stb),
    .mode(mode), .adv6(adv6), .adv2(adv2), .stat_sel(stat_sel)
  );

  assign tog_adv = {adv2, adv6};

  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    fsg_toggle u_t (
      .clk(clk), .rst_n(rst_sync_n),
      .adv(tog_adv[g]), .q(tog_q[g])
    );
  end

  assign tog6     = tog_q[0];
  assign tog2     = tog_q[1];
  assign op_erase = (op_kind != OP_PROG);

  always_comb begin
    stat_byte         = '0;
    stat_byte[SB_TOG] = tog6;
    unique case (mode)
      MD_BUSY: begin
        stat_byte[SB_POLL] = op_erase ? 1'b0 : ~pbit_q;
        stat_byte[SB_TMR]  = (op_kind == OP_CHIP) |
                             (op_erase & (op_kind != OP_CHIP) & erase_started);
        stat_byte[SB_ALT]  = op_erase & tog2;
      end
      MD_ERR: begin
        stat_byte[SB_POLL] = op_erase ? 1'b0 : ~pbit_q;
        stat_byte[SB_ERR]  = 1'b1;
        stat_byte[SB_TMR]  = op_erase;
        stat_byte[SB_ALT]  = op_erase & tog2;
      end
      MD_PROT: begin
        stat_byte[SB_POLL] = ~prot_ers & ~pbit_q;
        stat_byte[SB_TMR]  = prot_ers;
        stat_byte[SB_ALT]  = prot_ers & tog2;
      end
      MD_SUSP: begin
        stat_byte[SB_POLL] = 1'b1;
        stat_byte[SB_ALT]  = tog2;
      end
      default: begin
        stat_byte = '0;
      end
    endcase
  end

  assign rd_byte = stat_sel ? stat_byte : array_byte;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk
  import fsg_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       stat_sel,
  input logic [7:0] rd_byte,
  input logic       fail_evt,
  input logic       clr_cmd,
  input logic       prog_start,
  input logic       err_q,
  input logic       tog6,
  input logic       adv6,
  input fsg_mode_e  mode,
  input logic [1:0] op_kind
);
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_sel |-> (rd_byte[4] == 1'b0 && rd_byte[1:0] == 2'b00)); // R10
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adv6 |=> (tog6 != $past(tog6))); // R3
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_SUSP) |=> $stable(tog6)); // R3
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fail_evt |=> err_q); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fail_evt && !clr_cmd && !prog_start) |=> $stable(err_q)); // R4
  AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_SUSP && stat_sel) |-> rd_byte[7]); // R2
  AST_CHIP_TMR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MD_BUSY && op_kind == 2'b01) |-> rd_byte[3]); // R5
  AST_ERR_PRIO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |-> (mode == MD_ERR && stat_sel)); // R11
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .stat_sel(stat_sel), .rd_byte(rd_byte),
  .fail_evt(fail_evt), .clr_cmd(clr_cmd), .prog_start(prog_start),
  .err_q(err_q), .tog6(tog6), .adv6(adv6), .mode(mode), .op_kind(op_kind)
);

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  localparam int unsigned NUM_BLK = 19;
  localparam int unsigned BLK_W   = 5;
  localparam int unsigned P_PROG  = 250;
  localparam int unsigned P_ERASE = 25000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n;
  logic               eng_busy, eng_susp;
  logic [1:0]         op_kind;
  logic               erase_started, in_erase_blk;
  logic [BLK_W-1:0]   rd_blk;
  logic [NUM_BLK-1:0] blk_fail;
  logic               rd_stb, prog_start;
  logic [7:0]         prog_cur, prog_wdata;
  logic               prot_abort, prot_is_erase, fail_evt, clr_cmd;
  logic [7:0]         array_byte;
  logic [7:0]         rd_byte;
  logic               stat_sel;

  flash_status_gen #(.NUM_BLK(NUM_BLK), .PROT_PROG_CYC(P_PROG),
                     .PROT_ERASE_CYC(P_ERASE)) dut_i (.*);

  typedef struct {
    logic [7:0] b;
    logic       s;
    string      tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_fail = 0;
  logic e6 = 1'b0;
  logic e2 = 1'b0;

  always @(negedge clk) begin
    #1;
    if (rd_stb) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (rd_byte !== e.b || stat_sel !== e.s) begin
          n_fail++;
          $display("FAIL %s: actual byte %h sel %b, expected byte %h sel %b",
                   e.tag, rd_byte, stat_sel, e.b, e.s);
        end
      end
    end
  end

  task automatic rd_chk(input logic [7:0] b, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    e.b = b; e.s = s; e.tag = tag;
    q.push_back(e);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  function automatic logic [7:0] sb(logic b7, logic b5, logic b3);
    return {b7, e6, b5, 1'b0, b3, e2, 2'b00};
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; eng_busy = 0; eng_susp = 0; op_kind = 2'b00;
    erase_started = 0; in_erase_blk = 0; rd_blk = '0; blk_fail = '0;
    rd_stb = 0; prog_start = 0; prog_cur = 8'hFF; prog_wdata = 8'h80;
    prot_abort = 0; prot_is_erase = 0; fail_evt = 0; clr_cmd = 0;
    array_byte = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle passes array data
    rd_chk(8'h5A, 1'b0, "R1 idle after reset");

    // R2 R3: program, wdata bit7=1 so polling bit reads 0
    pulse(prog_start);
    eng_busy = 1; op_kind = 2'b00;
    for (int i = 0; i < 3; i++) begin
      rd_chk(sb(1'b0, 1'b0, 1'b0), 1'b1, "R2 R3 R6 program status");
      e6 = ~e6;
    end
    eng_busy = 0;
    rd_chk(8'h5A, 1'b0, "R1 back to array after program");

    // R4: 0-to-1 program attempt sets the error flag
    prog_cur = 8'h0F; prog_wdata = 8'h1F;
    pulse(prog_start);
    for (int i = 0; i < 2; i++) begin
      rd_chk(sb(1'b1, 1'b1, 1'b0), 1'b1, "R4 program 0-to-1 error");
      e6 = ~e6;
    end
    pulse(clr_cmd);
    rd_chk(8'h5A, 1'b0, "R4 cleared by reset command");
    @(negedge clk);
    fail_evt = 1; clr_cmd = 1;
    @(negedge clk);
    fail_evt = 0; clr_cmd = 0;
    rd_chk(sb(1'b1, 1'b1, 1'b0), 1'b1, "R4 set wins over clear");
    e6 = ~e6;
    pulse(clr_cmd);

    // R5 R6: chip erase
    eng_busy = 1; op_kind = 2'b01; in_erase_blk = 1;
    rd_chk(sb(1'b0, 1'b0, 1'b1), 1'b1, "R5 R6 chip erase erasing block");
    e6 = ~e6; e2 = ~e2;
    in_erase_blk = 0;
    for (int i = 0; i < 2; i++) begin
      rd_chk(sb(1'b0, 1'b0, 1'b1), 1'b1, "R6 chip erase other block steady");
      e6 = ~e6;
    end

    // R5: block erase before and after window close
    op_kind = 2'b10; in_erase_blk = 1; erase_started = 0;
    rd_chk(sb(1'b0, 1'b0, 1'b0), 1'b1, "R5 block erase collecting");
    e6 = ~e6; e2 = ~e2;
    erase_started = 1;
    rd_chk(sb(1'b0, 1'b0, 1'b1), 1'b1, "R5 block erase running");
    e6 = ~e6; e2 = ~e2;

    // R8 R2 R3: suspend
    eng_busy = 0; eng_susp = 1;
    for (int i = 0; i < 2; i++) begin
      rd_chk({1'b1, e6, 3'b000, e2, 2'b00}, 1'b1, "R8 R3 suspend erasing block");
      e2 = ~e2;
    end
    in_erase_blk = 0;
    rd_chk(8'h5A, 1'b0, "R8 suspend other block array");

    // R7: erase error with a failed block map
    eng_susp = 0; blk_fail = '0; blk_fail[3] = 1'b1;
    pulse(fail_evt);
    rd_blk = 5'd3;
    rd_chk(sb(1'b0, 1'b1, 1'b1), 1'b1, "R7 error read on failed block");
    e6 = ~e6; e2 = ~e2;
    rd_blk = 5'd5;
    rd_chk(sb(1'b0, 1'b1, 1'b1), 1'b1, "R7 error read on good block");
    e6 = ~e6;
    eng_busy = 1;
    rd_chk(sb(1'b0, 1'b1, 1'b1), 1'b1, "R11 error overrides busy");
    e6 = ~e6;
    eng_busy = 0;
    pulse(clr_cmd);
    rd_chk(8'h5A, 1'b0, "R4 error cleared");

    // R9: protected program window
    prog_wdata = 8'h00; prot_is_erase = 0;
    pulse(prot_abort);
    rd_chk({1'b1, e6, 6'b000000}, 1'b1, "R9 protected program window");
    e6 = ~e6;
    repeat (P_PROG + 10) @(negedge clk);
    rd_chk(8'h5A, 1'b0, "R9 program window closed");

    // R9: protected erase window
    prot_is_erase = 1; in_erase_blk = 1;
    pulse(prot_abort);
    for (int i = 0; i < 2; i++) begin
      rd_chk(sb(1'b0, 1'b0, 1'b1), 1'b1, "R9 protected erase window bit2 held");
      e6 = ~e6;
    end
    repeat (P_PROG + 10) @(negedge clk);
    rd_chk(sb(1'b0, 1'b0, 1'b1), 1'b1, "R9 erase window still open");
    e6 = ~e6;
    repeat (P_ERASE) @(negedge clk);
    rd_chk(8'h5A, 1'b0, "R9 erase window closed");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule